// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block is the power-management unit of a small microcontroller. While the core runs, a sleep strobe is accepted only when the sleep-enable bit is set. On an accepted strobe the block latches a 3-bit mode code and a 2-bit start-up delay select. It then drops the clock enables for the CPU, flash, I/O, ADC and asynchronous timer domains, and the main oscillator enable, to the pattern of that mode. Entering a light mode with the ADC enabled also fires a one-cycle conversion start pulse.

While asleep, the block qualifies the incoming wake requests against the latched mode. Each mode has its own set of accepted wake sources. The two light modes, idle and noise-reduction, restore every clock on the cycle after a qualifying request. The two deep modes stop the oscillator. After a wake request in a deep mode, the block first turns the oscillator back on and counts a selectable number of ticks of an always-running slow tick. When the count completes, it restores the clocks if the wake reason still stands. A request on a reset line leaves sleep at once from any state.

Top module: `sleepClkCtrl`

## Requirements
- R1: After `rstN` is released, every clock enable output and `oscEn` are 1, `asleep` is 0 and `adcStart` is 0.
- R2: A `sleepStrobe` is ignored when `sleepEn` is 0 or when `resetReq` is 1 in the same cycle, so `asleep` stays 0.
- R3: Mode codes 000, 100, 101, 110 and 111 select idle. In idle, `cpuClkEn` and `flashClkEn` are 0, while `ioClkEn`, `adcClkEn`, `asyncClkEn` and `oscEn` are 1.
- R4: Mode code 001 selects noise-reduction. In this mode the CPU, flash and I/O enables are 0, while `adcClkEn`, `asyncClkEn` and `oscEn` are 1.
- R5: Mode code 010 selects power-down. In this mode every clock enable and `oscEn` are 0.
- R6: Mode code 011 selects power-save. It gates like power-down, except that `asyncClkEn` follows `asyncTimerSel`.
- R7: `adcStart` is a single-cycle pulse. It is high in the first sleeping cycle after entry to idle or noise-reduction while `adcEnable` is 1. It is never raised for power-down or power-save, or when `adcEnable` is 0.
- R8: Accepted wake sources depend on the mode:
  - Idle accepts `anyIrq` or any source listed for noise-reduction.
  - Noise-reduction accepts `adcDone`, `spmReady`, `twiMatch`, either `extLevel` bit, or a timer interrupt. A timer interrupt means `globalIe` is 1 and either overflow or compare is asserted together with its own enable.
  - Power-down accepts only `twiMatch` or an `extLevel` bit.
- R9: In power-save, a timer interrupt wakes the block in addition to the power-down sources, but only when `asyncTimerSel` is 1.
- R10: In idle or noise-reduction, a qualifying request restores all clock enables and clears `asleep` at the next clock edge.
- R11: In power-down or power-save, a qualifying request raises `oscEn` at the next edge while the other enables stay 0. The other enables return once 4, 64, 1024 or 16384 cycles with `slowTick` high have passed, for delay select 0, 1, 2 or 3 respectively. Cycles with `slowTick` low do not count.
- R12: If the deep-mode wake was caused only by `extLevel`, and no `extLevel` bit is high when the delay completes, the block returns to the same sleep mode instead of waking.
- R13: `resetReq` in any state makes the next cycle awake with all enables 1 and clears the latched sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, always running |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | Enable pulse from the always-running slow clock |
| sleepEn | input | 1 | Sleep enable bit |
| sleepStrobe | input | 1 | Sleep instruction strobe |
| modeSel | input | 3 | Sleep mode code |
| startSel | input | 2 | Start-up delay select |
| adcEnable | input | 1 | ADC enabled |
| asyncTimerSel | input | 1 | Asynchronous timer clocked from its own oscillator |
| resetReq | input | 1 | Any reset request (external, watchdog, brown-out) |
| anyIrq | input | 1 | Any enabled interrupt pending |
| adcDone | input | 1 | ADC conversion complete |
| twiMatch | input | 1 | Two-wire address match |
| spmReady | input | 1 | Store-program or EEPROM ready |
| timerOvf | input | 1 | Asynchronous timer overflow |
| timerCmp | input | 1 | Asynchronous timer compare match |
| timerOvfIe | input | 1 | Overflow interrupt enable |
| timerCmpIe | input | 1 | Compare interrupt enable |
| globalIe | input | 1 | Global interrupt enable |
| extLevel | input | 2 | Level state of the two external interrupt lines |
| cpuClkEn | output | 1 | CPU clock enable |
| flashClkEn | output | 1 | Flash clock enable |
| ioClkEn | output | 1 | I/O clock enable |
| adcClkEn | output | 1 | ADC clock enable |
| asyncClkEn | output | 1 | Asynchronous timer clock enable |
| oscEn | output | 1 | Main oscillator enable |
| adcStart | output | 1 | ADC conversion start pulse |
| asleep | output | 1 | Sleeping or waiting out the start-up delay |

## Verification
All eight mode codes are swept through a vector table, with the ADC enable and asynchronous-timer select varied. This separates the four gating patterns from each other and shows that the codes above 011 collapse to idle. Each wake source is then presented to modes that must accept it and to modes that must ignore it. This separates the per-mode wake sets, including the power-save timer source and the enables it depends on. Deep-mode wakes are timed at delay selects 0, 1 and 3, and once with the slow tick paused. The aim is to expose off-by-one errors in the start-up count. A level that drops during the delay is compared with one that holds, to show the return to sleep.

// File: rtl/sleepClkPkg.sv
package sleepClkPkg;
  typedef enum logic [2:0] {
    SM_IDLE  = 3'd0,
    SM_NOISE = 3'd1,
    SM_PDOWN = 3'd2,
    SM_PSAVE = 3'd3
  } sleepMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic clearCfg;
    logic loadCnt;
    logic runCnt;
    logic sleeping;
    logic starting;
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic wakeHit;
    logic needDelay;
    logic delayDone;
    logic levelOk;
  } dpStat_t;
endpackage

// File: rtl/slpControl.sv
module slpControl
  import sleepClkPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sleepEn,
  input  logic     sleepStrobe,
  input  logic     resetReq,
  input  dpStat_t  dpStat,
  output ctlStrb_t ctlStrb
);
  typedef enum logic [1:0] {ST_ACTIVE, ST_SLEEP, ST_START} ctlState_e;
  ctlState_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    ctlStrb = '0;
    ctlStrb.sleeping = (stateQ == ST_SLEEP);
    ctlStrb.starting = (stateQ == ST_START);
    if (resetReq) begin
      stateNext = ST_ACTIVE;
      ctlStrb.clearCfg = 1'b1;
    end else begin
      unique case (stateQ)
        ST_ACTIVE: if (sleepStrobe && sleepEn) begin
          stateNext = ST_SLEEP;
          ctlStrb.latchCfg = 1'b1;
        end
        ST_SLEEP: if (dpStat.wakeHit) begin
          if (dpStat.needDelay) begin
            stateNext = ST_START;
            ctlStrb.loadCnt = 1'b1;
          end else begin
            stateNext = ST_ACTIVE;
          end
        end
        ST_START: begin
          ctlStrb.runCnt = 1'b1;
          if (dpStat.delayDone)
            stateNext = dpStat.levelOk ? ST_ACTIVE : ST_SLEEP;
        end
        default: stateNext = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACTIVE;
    else       stateQ <= stateNext;
  end
endmodule

// File: rtl/slpDatapath.sv
module slpDatapath
  import sleepClkPkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 2,
  parameter int STEP_LOG2 = 4,
  parameter int EXT_N     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         ctlStrb,
  input  logic             slowTick,
  input  logic [2:0]       modeSel,
  input  logic [SEL_W-1:0] startSel,
  input  logic             adcEnable,
  input  logic             asyncTimerSel,
  input  logic             anyIrq,
  input  logic             adcDone,
  input  logic             twiMatch,
  input  logic             spmReady,
  input  logic             timerOvf,
  input  logic             timerCmp,
  input  logic             timerOvfIe,
  input  logic             timerCmpIe,
  input  logic             globalIe,
  input  logic [EXT_N-1:0] extLevel,
  output dpStat_t          dpStat,
  output logic [5:0]       gateVec,
  output logic             adcStart
);
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

  sleepMode_e       modeQ, effMode;
  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] cntQ, limitM1;
  logic [CNT_W:0]   fullCnt;
  logic             edgeWakeQ, adcStartQ;
  logic             timerIrq, levelAny, deepWake, psTimer, deepMode;

  always_comb begin
    if (modeSel[2]) effMode = SM_IDLE;
    else            effMode = sleepMode_e'(modeSel);
  end

  assign timerIrq = globalIe & ((timerOvf & timerOvfIe) | (timerCmp & timerCmpIe));
  assign levelAny = |extLevel;
  assign deepWake = twiMatch | levelAny;
  assign psTimer  = asyncTimerSel & timerIrq;
  assign deepMode = (modeQ == SM_PDOWN) || (modeQ == SM_PSAVE);

  assign fullCnt = (CNT_W + 1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(selQ));
  assign limitM1 = CNT_W'(fullCnt - 1'b1);

  always_comb begin
    unique case (modeQ)
      SM_IDLE:  dpStat.wakeHit = anyIrq | adcDone | spmReady | timerIrq | deepWake;
      SM_NOISE: dpStat.wakeHit = adcDone | spmReady | timerIrq | deepWake;
      SM_PDOWN: dpStat.wakeHit = deepWake;
      SM_PSAVE: dpStat.wakeHit = deepWake | psTimer;
      default:  dpStat.wakeHit = 1'b1;
    endcase
    dpStat.needDelay = deepMode;
    dpStat.delayDone = ctlStrb.runCnt & slowTick & (cntQ == limitM1);
    dpStat.levelOk   = edgeWakeQ | levelAny;
  end

  // gateVec order: cpu, flash, io, adc, async, osc
  always_comb begin
    if (!ctlStrb.sleeping && !ctlStrb.starting) begin
      gateVec = 6'b111111;
    end else begin
      unique case (modeQ)
        SM_IDLE:  gateVec = 6'b001111;
        SM_NOISE: gateVec = 6'b000111;
        SM_PSAVE: gateVec = {4'b0000, asyncTimerSel, ctlStrb.starting};
        default:  gateVec = {5'b00000, ctlStrb.starting};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= SM_IDLE;
      selQ      <= '0;
      cntQ      <= '0;
      edgeWakeQ <= 1'b0;
      adcStartQ <= 1'b0;
    end else begin
      adcStartQ <= 1'b0;
      if (ctlStrb.clearCfg) begin
        modeQ     <= SM_IDLE;
        cntQ      <= '0;
        edgeWakeQ <= 1'b0;
      end else if (ctlStrb.latchCfg) begin
        modeQ     <= effMode;
        selQ      <= startSel;
        adcStartQ <= adcEnable & ((effMode == SM_IDLE) || (effMode == SM_NOISE));
      end else if (ctlStrb.loadCnt) begin
        cntQ      <= '0;
        edgeWakeQ <= twiMatch | ((modeQ == SM_PSAVE) & psTimer);
      end else if (ctlStrb.runCnt && slowTick) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign adcStart = adcStartQ;
endmodule

// File: rtl/sleepClkCtrl.sv
module sleepClkCtrl
  import sleepClkPkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 2,
  parameter int STEP_LOG2 = 4,
  parameter int EXT_N     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             sleepEn,
  input  logic             sleepStrobe,
  input  logic [2:0]       modeSel,
  input  logic [SEL_W-1:0] startSel,
  input  logic             adcEnable,
  input  logic             asyncTimerSel,
  input  logic             resetReq,
  input  logic             anyIrq,
  input  logic             adcDone,
  input  logic             twiMatch,
  input  logic             spmReady,
  input  logic             timerOvf,
  input  logic             timerCmp,
  input  logic             timerOvfIe,
  input  logic             timerCmpIe,
  input  logic             globalIe,
  input  logic [EXT_N-1:0] extLevel,
  output logic             cpuClkEn,
  output logic             flashClkEn,
  output logic             ioClkEn,
  output logic             adcClkEn,
  output logic             asyncClkEn,
  output logic             oscEn,
  output logic             adcStart,
  output logic             asleep
);
  ctlStrb_t   ctlStrb;
  dpStat_t    dpStat;
  logic [5:0] gateVec;

  slpControl u_ctl (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .sleepStrobe(sleepStrobe),
    .resetReq(resetReq), .dpStat(dpStat), .ctlStrb(ctlStrb)
  );

  slpDatapath #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .EXT_N(EXT_N)) u_dp (
    .clk(clk), .rstN(rstN), .ctlStrb(ctlStrb), .slowTick(slowTick),
    .modeSel(modeSel), .startSel(startSel), .adcEnable(adcEnable),
    .asyncTimerSel(asyncTimerSel), .anyIrq(anyIrq), .adcDone(adcDone),
    .twiMatch(twiMatch), .spmReady(spmReady), .timerOvf(timerOvf),
    .timerCmp(timerCmp), .timerOvfIe(timerOvfIe), .timerCmpIe(timerCmpIe),
    .globalIe(globalIe), .extLevel(extLevel), .dpStat(dpStat),
    .gateVec(gateVec), .adcStart(adcStart)
  );

  assign {cpuClkEn, flashClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn} = gateVec;
  assign asleep = ctlStrb.sleeping | ctlStrb.starting;
endmodule

// File: rtl/sleepClkCtrlChk.sv
module sleepClkCtrlChk #(
  parameter int SEL_W = 2,
  parameter int EXT_N = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             sleepEn,
  input logic             sleepStrobe,
  input logic             resetReq,
  input logic [SEL_W-1:0] startSel,
  input logic [EXT_N-1:0] extLevel,
  input logic             cpuClkEn,
  input logic             flashClkEn,
  input logic             ioClkEn,
  input logic             adcClkEn,
  input logic             asyncClkEn,
  input logic             oscEn,
  input logic             adcStart,
  input logic             asleep
);
  // R13
  reset_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (cpuClkEn && flashClkEn && ioClkEn && adcClkEn && asyncClkEn && oscEn && !asleep));

  // R7
  adc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R2
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!asleep && sleepStrobe && !sleepEn) |=> !asleep);

  // R5
  osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !ioClkEn && !adcClkEn && asleep));

  // R3
  cpu_flash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |-> !flashClkEn);

  // R11
  no_skip_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !oscEn && !resetReq) |=> !cpuClkEn);

  // R10
  awake_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !asleep |-> (cpuClkEn && ioClkEn && asyncClkEn && oscEn));
endmodule

bind sleepClkCtrl sleepClkCtrlChk #(.SEL_W(SEL_W), .EXT_N(EXT_N)) u_chk (.*);

// File: tb/sleepClkCtrl_bench.sv
module sleepClkCtrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b1, sleepEn = 1'b0, sleepStrobe = 1'b0;
  logic [2:0] modeSel = '0;
  logic [1:0] startSel = '0;
  logic adcEnable = 0, asyncTimerSel = 0, resetReq = 0, anyIrq = 0, adcDone = 0;
  logic twiMatch = 0, spmReady = 0, timerOvf = 0, timerCmp = 0;
  logic timerOvfIe = 0, timerCmpIe = 0, globalIe = 0;
  logic [1:0] extLevel = '0;
  logic cpuClkEn, flashClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn, adcStart, asleep;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleepClkCtrl u_sleepClkCtrl (.*);

  wire [5:0] gates = {cpuClkEn, flashClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn};

  // {mode, adcEnable, asyncTimerSel, expected gates, expected adcStart}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b0, 6'b001111, 1'b1},
    {3'b001, 1'b1, 1'b0, 6'b000111, 1'b1},
    {3'b010, 1'b1, 1'b1, 6'b000000, 1'b0},
    {3'b011, 1'b1, 1'b1, 6'b000010, 1'b0},
    {3'b011, 1'b0, 1'b0, 6'b000000, 1'b0},
    {3'b100, 1'b0, 1'b0, 6'b001111, 1'b0},
    {3'b101, 1'b1, 1'b0, 6'b001111, 1'b1},
    {3'b110, 1'b1, 1'b0, 6'b001111, 1'b1},
    {3'b111, 1'b0, 1'b0, 6'b001111, 1'b0},
    {3'b001, 1'b0, 1'b0, 6'b000111, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterSleep(input logic [2:0] m, input logic [1:0] s);
    sleepEn = 1; modeSel = m; startSel = s; sleepStrobe = 1;
    step();
    sleepStrobe = 0;
  endtask

  task automatic doReset();
    resetReq = 1;
    step();
    resetReq = 0;
    chk("R13 enables", 32'(gates), 32'h3f);
    chk("R13 asleep", 32'(asleep), 0);
  endtask

  task automatic deepRun(input logic [1:0] s, input int n);
    enterSleep(3'b010, s);
    twiMatch = 1;
    step();
    twiMatch = 0;
    chk("R11 osc on", 32'(oscEn), 1);
    chk("R11 cpu held", 32'(cpuClkEn), 0);
    step(n - 1);
    chk("R11 before end", 32'(cpuClkEn), 0);
    step();
    chk("R11 restored", 32'(gates), 32'h3f);
  endtask

  initial begin
    step(3);
    rstN = 1;
    step();
    chk("R1 enables", 32'(gates), 32'h3f);
    chk("R1 asleep", 32'(asleep), 0);
    chk("R1 adcStart", 32'(adcStart), 0);

    // R2: strobe with enable low, and strobe masked by reset
    sleepEn = 0; sleepStrobe = 1;
    step();
    chk("R2 no enable", 32'(asleep), 0);
    sleepEn = 1; resetReq = 1;
    step();
    sleepStrobe = 0; resetReq = 0;
    chk("R2 reset masks", 32'(asleep), 0);

    // mode sweep: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [2:0] m;
      string tag;
      m = VEC[i][11:9];
      adcEnable = VEC[i][8];
      asyncTimerSel = VEC[i][7];
      tag = (m == 3'b001) ? "R4" : (m == 3'b010) ? "R5" : (m == 3'b011) ? "R6" : "R3";
      enterSleep(m, 2'd0);
      chk(tag, 32'(gates), 32'(VEC[i][6:1]));
      chk("R7 pulse", 32'(adcStart), 32'(VEC[i][0]));
      step();
      chk("R7 one cycle", 32'(adcStart), 0);
      chk(tag, 32'(gates), 32'(VEC[i][6:1]));
      doReset();
    end
    adcEnable = 0; asyncTimerSel = 0;

    // R10 idle wakes on anyIrq
    enterSleep(3'b000, 0);
    anyIrq = 1;
    step();
    anyIrq = 0;
    chk("R10 idle wake", 32'(gates), 32'h3f);

    // R8 noise-reduction ignores anyIrq, wakes on adcDone / spmReady
    enterSleep(3'b001, 0);
    anyIrq = 1;
    step(3);
    anyIrq = 0;
    chk("R8 nr ignores anyIrq", 32'(asleep), 1);
    adcDone = 1;
    step();
    adcDone = 0;
    chk("R10 nr wake", 32'(gates), 32'h3f);
    enterSleep(3'b001, 0);
    spmReady = 1;
    step();
    spmReady = 0;
    chk("R8 nr spm wake", 32'(asleep), 0);

    // R8 power-down ignores adc, spm, anyIrq and timer
    enterSleep(3'b010, 0);
    adcDone = 1; spmReady = 1; anyIrq = 1; asyncTimerSel = 1;
    timerOvf = 1; timerOvfIe = 1; globalIe = 1;
    step(3);
    chk("R8 pd ignores", 32'(asleep), 1);
    chk("R8 pd osc off", 32'(oscEn), 0);
    adcDone = 0; spmReady = 0; anyIrq = 0; timerOvf = 0; timerOvfIe = 0; globalIe = 0;
    asyncTimerSel = 0;
    doReset();

    // R9 power-save timer wake qualifiers
    enterSleep(3'b011, 0);
    timerOvf = 1; timerOvfIe = 1; globalIe = 1; asyncTimerSel = 0;
    step(3);
    chk("R9 async sel low", 32'(oscEn), 0);
    asyncTimerSel = 1; globalIe = 0;
    step(3);
    chk("R9 global ie low", 32'(oscEn), 0);
    timerOvfIe = 0; timerCmp = 1; globalIe = 1;
    step(3);
    chk("R9 compare no ie", 32'(oscEn), 0);
    timerCmpIe = 1;
    step();
    chk("R9 timer wake osc", 32'(oscEn), 1);
    chk("R9 timer wake cpu", 32'(cpuClkEn), 0);
    timerOvf = 0; timerCmp = 0; timerCmpIe = 0; globalIe = 0; asyncTimerSel = 0;
    step(4);
    chk("R9 restored", 32'(gates), 32'h3f);

    // R11 delay lengths
    deepRun(2'd0, 4);
    deepRun(2'd1, 64);
    deepRun(2'd3, 16384);

    // R11 paused slow tick
    enterSleep(3'b010, 0);
    twiMatch = 1;
    step();
    twiMatch = 0; slowTick = 0;
    step(10);
    chk("R11 paused", 32'(cpuClkEn), 0);
    slowTick = 1;
    step(3);
    chk("R11 paused before", 32'(cpuClkEn), 0);
    step();
    chk("R11 paused end", 32'(cpuClkEn), 1);

    // R12 level dropped then held
    enterSleep(3'b010, 0);
    extLevel = 2'b01;
    step();
    extLevel = 2'b00;
    step(4);
    chk("R12 back asleep", 32'(asleep), 1);
    chk("R12 osc off", 32'(oscEn), 0);
    extLevel = 2'b10;
    step(5);
    chk("R12 held wakes", 32'(gates), 32'h3f);
    extLevel = 2'b00;

    // R13 reset during start-up
    enterSleep(3'b010, 1);
    twiMatch = 1;
    step();
    twiMatch = 0;
    step(5);
    chk("R13 mid delay", 32'(asleep), 1);
    doReset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule